// File: doc/BRIEF.md
# Six-Switch Unipolar Sine-PWM Gate Generator

This block drives the six gates of a single-phase bridge built from two half-bridge legs plus two middle polarity switches. A signed control sample, already locked to the grid voltage by an upstream generator, is compared against a symmetric triangular carrier and against zero. During the positive half of the grid cycle, one diagonal pair of switches is chopped at the carrier rate and one middle switch is held on as a polarity selector. During the negative half, the other diagonal pair and the other middle switch take over. Both switches of a chopped pair share a single gate term, so there is no dead time between them.

The carrier is an up/down counter. It climbs from zero to a programmable peak and then falls back, so one PWM period lasts twice the peak in clock cycles. A peak of 833 at a 50 MHz clock gives roughly 30 kHz. The control sample is captured only at the carrier valley, so duty and polarity are fixed for a whole PWM period. A strobe marks every valley so that the upstream sine source can present the next sample in time.

Top module: `h6_spwm_gen`

## Requirements
- R1: While enabled with peak P >= 1, the carrier runs 0,1..P,P-1..1 and repeats, so a period is 2P cycles. `valley` is high exactly in the cycle where the carrier is 0. The first cycle after enable rises is a valley cycle.
- R2: The positive chopped pair, `gates[0]` (top of leg A) and `gates[1]` (bottom of leg B), is high only when the latched sample is positive. It is high in every non-valley cycle whose carrier value is below the sample magnitude. It is never high in a valley cycle.
- R3: The positive selector `gates[2]` is high for the whole period after a valley that latched a positive sample.
- R4: The negative chopped pair, `gates[3]` (top of leg B) and `gates[4]` (bottom of leg A), uses the negation of a negative sample as its magnitude. The most negative code gives magnitude 2^(CW-1). Otherwise it follows the rule of R2.
- R5: The negative selector `gates[5]` is high for the whole period after a valley that latched a negative sample.
- R6: A latched sample of zero keeps all six gates low for that period.
- R7: The two gates of each chopped pair are equal in every cycle, with no dead time.
- R8: `ctrl` is captured only on the clock edge that ends a valley cycle. A change at any other time has no effect on the gates until that edge, so selectors switch only right after a valley.
- R9: The two selectors are never high together, and a chopped gate is high only while the selector of its own polarity is high.
- R10: While `rst_n` is low, or from the cycle after `en` is sampled low, all gates and `valley` are low. The carrier restarts from zero when `en` returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable |
| ctrl | input | CW | Signed control sample |
| peak | input | PW | Carrier peak count (half period in cycles) |
| gates | output | 6 | Gate bits, positions as in R2 to R5 |
| valley | output | 1 | High in carrier-valley cycles |

## Verification
A wrong carrier state appears as a valley strobe that lands away from the 2P boundary, or as a count of chopped cycles that differs from the magnitude rule. Either shows within one PWM period. A corrupted polarity or magnitude register shows up as a selector that flips between valleys, or as pair activity under the wrong selector, in the first cycle after the faulty edge. The bench counts the chopped cycles per period for several magnitudes, including the saturating and most-negative cases. It also probes a mid-period sign change to confirm that nothing moves before the valley edge.

// File: rtl/h6_spwm_gen.sv
`timescale 1ns/1ps
module h6_spwm_gen #(
  parameter int CW = 12,
  parameter int PW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [CW-1:0] ctrl,
  input  logic        [PW-1:0] peak,
  output logic        [5:0]    gates,
  output logic                 valley
);

  localparam int MW = (CW > PW) ? CW : PW;
  localparam logic [PW-1:0] STEP = PW'(1);
  localparam logic [CW-1:0] UNIT = CW'(1);

  typedef enum logic [1:0] {POL_NONE, POL_POS, POL_NEG} pol_t;

  logic          run;
  logic          up;
  logic [PW-1:0] cnt;
  logic [CW-1:0] mag;
  pol_t          pol;
  logic [CW-1:0] ctrl_abs;
  logic          chop;

  assign ctrl_abs = ctrl[CW-1] ? (~ctrl + UNIT) : ctrl;
  assign valley   = run && (cnt == '0);
  assign chop     = run && !valley && (MW'(mag) > MW'(cnt));

  assign gates[0] = chop && (pol == POL_POS);
  assign gates[1] = chop && (pol == POL_POS);
  assign gates[2] = run  && (pol == POL_POS);
  assign gates[3] = chop && (pol == POL_NEG);
  assign gates[4] = chop && (pol == POL_NEG);
  assign gates[5] = run  && (pol == POL_NEG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      up  <= 1'b1;
      cnt <= '0;
      mag <= '0;
      pol <= POL_NONE;
    end else if (!en) begin
      run <= 1'b0;
      up  <= 1'b1;
      cnt <= '0;
      mag <= '0;
      pol <= POL_NONE;
    end else begin
      run <= 1'b1;
      if (valley) begin
        mag <= ctrl_abs;
        if (ctrl == '0)       pol <= POL_NONE;
        else if (ctrl[CW-1])  pol <= POL_NEG;
        else                  pol <= POL_POS;
      end
      if (run) begin
        if (up) begin
          if (cnt >= peak) begin
            up  <= 1'b0;
            cnt <= (cnt == '0) ? '0 : cnt - STEP;
          end else begin
            cnt <= cnt + STEP;
          end
        end else begin
          if (cnt == '0) begin
            up  <= 1'b1;
            cnt <= (peak == '0) ? '0 : STEP;
          end else begin
            cnt <= cnt - STEP;
          end
        end
      end
    end
  end

endmodule

// File: rtl/h6_spwm_gen_chk.sv
`timescale 1ns/1ps
module h6_spwm_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [5:0] gates,
  input logic       valley
);

  p_pair_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gates[0] == gates[1]) && (gates[3] == gates[4]));

  p_sel_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(gates[2] && gates[5]));

  p_chop_own_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gates[0] || gates[3]) |-> ((gates[0] && gates[2]) || (gates[3] && gates[5])));

  p_valley_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valley |-> (!gates[0] && !gates[3]));

  p_sel_at_valley_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(en) && (!$stable(gates[2]) || !$stable(gates[5]))) |-> $past(valley));

  p_off_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(en)) |-> ((gates == 6'b0) && !valley));

endmodule

bind h6_spwm_gen h6_spwm_gen_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .en    (en),
  .gates (gates),
  .valley(valley)
);

// File: tb/test_h6_spwm_gen.sv
`timescale 1ns/1ps
module test_h6_spwm_gen;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               en = 1'b0;
  logic signed [11:0] ctrl = '0;
  logic        [11:0] peak = 12'd4;
  logic        [5:0]  gates;
  logic               valley;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  h6_spwm_gen #(.CW(12), .PW(12)) i_h6_spwm_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .ctrl(ctrl), .peak(peak),
    .gates(gates), .valley(valley)
  );

  typedef struct packed {
    logic signed [11:0] c;
    logic [11:0]        p;
    logic [7:0]         npos;
    logic [7:0]         nneg;
    logic               spos;
    logic               sneg;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{ 12'sd2,     12'd4, 8'd2,  8'd0,  1'b1, 1'b0},
    '{-12'sd3,     12'd4, 8'd0,  8'd4,  1'b0, 1'b1},
    '{ 12'sd0,     12'd4, 8'd0,  8'd0,  1'b0, 1'b0},
    '{ 12'sd100,   12'd4, 8'd7,  8'd0,  1'b1, 1'b0},
    '{-12'sd2048,  12'd6, 8'd0,  8'd11, 1'b0, 1'b1},
    '{ 12'sd1,     12'd5, 8'd0,  8'd0,  1'b1, 1'b0},
    '{ 12'sd6,     12'd6, 8'd10, 8'd0,  1'b1, 1'b0},
    '{-12'sd7,     12'd6, 8'd0,  8'd11, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_valley();
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (valley) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(gates == 6'b0, "R10 gates in reset", gates, 0);
    chk(valley == 1'b0, "R10 valley in reset", valley, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gates == 6'b0 && !valley, "R10 idle while disabled", {valley, gates}, 0);
    en = 1'b1;
    @(negedge clk);
    chk(valley == 1'b1, "R1 first cycle after enable is valley", valley, 1);

    foreach (VECS[v]) begin
      int np, nn, sp, sn, mis, vl, plen;
      ctrl = VECS[v].c;
      peak = VECS[v].p;
      wait_valley();
      plen = 2 * int'(VECS[v].p);
      np = 0; nn = 0; sp = 0; sn = 0; mis = 0; vl = 0;
      for (int i = 0; i < plen; i++) begin
        @(negedge clk);
        np += gates[0];
        nn += gates[3];
        sp += gates[2];
        sn += gates[5];
        if (gates[0] != gates[1] || gates[3] != gates[4]) mis++;
        if (i < plen - 1) vl += valley;
        else chk(valley == 1'b1, "R1 valley closes period", valley, 1);
      end
      chk(vl == 0, "R1 no early valley", vl, 0);
      chk(np == int'(VECS[v].npos), "R2 positive pair on-cycles", np, VECS[v].npos);
      chk(nn == int'(VECS[v].nneg), "R4 negative pair on-cycles", nn, VECS[v].nneg);
      chk(sp == (VECS[v].spos ? plen : 0), "R3 positive selector", sp, VECS[v].spos ? plen : 0);
      chk(sn == (VECS[v].sneg ? plen : 0), "R5 negative selector", sn, VECS[v].sneg ? plen : 0);
      chk(mis == 0, "R7 pair mismatch cycles", mis, 0);
      if (VECS[v].c == 0)
        chk(np + nn + sp + sn == 0, "R6 zero sample keeps gates low", np + nn + sp + sn, 0);
    end

    begin
      int bad;
      ctrl = 12'sd5;
      peak = 12'd6;
      wait_valley();
      @(negedge clk);
      ctrl = -12'sd5;
      bad = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (!gates[2] || gates[5] || gates[3]) bad++;
        if (valley) break;
      end
      chk(bad == 0, "R8 mid-period sign change ignored", bad, 0);
      @(negedge clk);
      chk(gates[2] == 1'b0 && gates[5] == 1'b1, "R8 selector swap after valley", gates, 6'b100000);
      chk(!(gates[2] && gates[5]), "R9 selectors exclusive", gates, 0);
    end

    begin
      int cyc;
      en = 1'b0;
      @(negedge clk);
      chk(gates == 6'b0 && !valley, "R10 disable clears outputs", {valley, gates}, 0);
      en = 1'b1;
      @(negedge clk);
      chk(valley == 1'b1 && gates == 6'b0, "R10 restart at carrier zero", {valley, gates}, 64);
      cyc = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        cyc++;
        if (valley) break;
      end
      chk(cyc == 12, "R1 period after restart", cyc, 12);
      rst_n = 1'b0;
      #1;
      chk(gates == 6'b0 && !valley, "R10 reset clears outputs", {valley, gates}, 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule